// File: doc/BRIEF.md
# In-Order Acknowledge Latency Pipeline

This block produces the bus acknowledge, together with a caller-supplied tag, for each read and write request that a memory controller issues. Reads need a fixed number of cycles before their data is available. Writes could be answered much sooner. The only rule is that no acknowledge may overtake one that belongs to an earlier request.

The block is a shift register of `{tag, ack}` slots that moves one place toward slot 0 on every clock. A registered output stage presents slot 0 on the ports.

- **Reads** always enter at the top slot, so they see the full latency.
- **Writes** enter at a tracked insertion slot. This slot sits just behind the most recent read still in flight. When no read is in flight, it sits at the lowest legal slot, which is 1.
- **Suppressed requests** are internally generated requests flagged by the caller. They occupy a slot like any other request, but carry a zero ack bit, so no acknowledge appears on the bus for them.

Top module: `ack_order_pipe`

## Requirements
- R1: After reset, `ack_o` and `tag_o` are 0 and the write-insertion slot is 1. A write issued on the first cycle after reset is therefore acknowledged 2 cycles after the edge that samples it.
- R2: A read sampled at edge k is acknowledged, with its own tag, exactly DEPTH edges later (visible after edge k+DEPTH).
- R3: A write issued while no read is in flight is acknowledged 2 edges after it is sampled.
- R4: A write issued on the cycle directly after a read is acknowledged on the cycle directly after that read's acknowledge.
- R5: A write sampled n cycles after a read is acknowledged max(DEPTH-n+1, 2) edges after it is sampled. Consecutive writes are acknowledged on consecutive cycles.
- R6: A request issued with `quiet_i` = 1 produces no acknowledge, yet still holds its place in the order of later acknowledges.
- R7: Acknowledges leave in issue order, with no `ack_o` pulse that belongs to no request. A write's acknowledge falls no later than DEPTH edges after issue.
- R8: With at most one strobe per cycle (`rd_issue_i` and `wr_issue_i` never both 1), the write-insertion slot stays within 1..DEPTH-1. Hence every write latency lies between 2 and DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_issue_i | input | 1 | A read request is issued this cycle |
| wr_issue_i | input | 1 | A write request is issued this cycle |
| tag_i | input | TAG_W | Tag carried with the request |
| quiet_i | input | 1 | Suppress the acknowledge for this request |
| ack_o | output | 1 | Registered acknowledge |
| tag_o | output | TAG_W | Tag belonging to the acknowledge |

## Verification
**Collisions at the output.** A write acknowledge can land on the cycle directly after a read acknowledge. It can also be pulled toward a slot that an earlier entry has just left. Ordering depends on the two never landing in the same cycle.

**How the bench provokes them.** It issues a write straight after a read, and after gaps of one to several cycles. It also issues back-to-back write bursts and random mixes.

**How results are judged.** A scoreboard forecasts each acknowledge cycle from the requirements: the later of "issue plus 2" and "previous expected acknowledge plus 1". Any acknowledge that is early, late, missing or extra counts as a miscompare.

// File: rtl/ackp_pkg.sv
package ackp_pkg;

    typedef enum logic [1:0] {
        ISS_NONE  = 2'd0,
        ISS_READ  = 2'd1,
        ISS_WRITE = 2'd2
    } iss_kind_e;

    function automatic iss_kind_e iss_decode(input logic rd, input logic wr);
        if (rd)      return ISS_READ;
        else if (wr) return ISS_WRITE;
        else         return ISS_NONE;
    endfunction

endpackage

// File: rtl/ackp_slot_ctrl.sv
module ackp_slot_ctrl
    import ackp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  iss_kind_e     kind_i,
    output logic [IW-1:0] slot_o
);

    localparam logic [IW-1:0] SLOT_TOP = IW'(DEPTH - 1);
    localparam logic [IW-1:0] SLOT_MIN = IW'(1);

    typedef struct packed {
        logic [IW-1:0] slot;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (kind_i)
            ISS_READ:  st_d.slot = SLOT_TOP;
            ISS_WRITE: st_d.slot = st_q.slot;
            default:   st_d.slot = (st_q.slot > SLOT_MIN) ? st_q.slot - 1'b1 : SLOT_MIN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.slot <= SLOT_MIN;
        else        st_q      <= st_d;
    end

    assign slot_o = st_q.slot;

    // R8
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o >= SLOT_MIN) && (slot_o <= SLOT_TOP));

    // R4
    slot_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == ISS_READ) |=> (slot_o == SLOT_TOP));

    // R5
    slot_hold_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == ISS_WRITE) |=> $stable(slot_o));

    // R5
    slot_follow_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == ISS_NONE && slot_o > SLOT_MIN) |=> (slot_o == $past(slot_o) - 1'b1));

endmodule

// File: rtl/ackp_shift_pipe.sv
module ackp_shift_pipe
    import ackp_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int EW    = 5,
    localparam int IW   = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  iss_kind_e     kind_i,
    input  logic [IW-1:0] slot_i,
    input  logic [EW-1:0] entry_i,
    output logic [EW-1:0] head_o,
    output logic [EW-1:0] top_o
);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] ent;
    } pipe_st_t;

    pipe_st_t st_d, st_q;
    logic [DEPTH-1:0][EW-1:0] shifted;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            if (g == DEPTH - 1) begin : g_top
                assign shifted[g] = '0;
            end else begin : g_mid
                assign shifted[g] = st_q.ent[g+1];
            end
        end
    endgenerate

    always_comb begin
        st_d.ent = shifted;
        for (int i = 0; i < DEPTH; i++) begin
            if (kind_i == ISS_READ && i == DEPTH - 1)
                st_d.ent[i] = entry_i;
            else if (kind_i == ISS_WRITE && slot_i == IW'(i))
                st_d.ent[i] = entry_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.ent <= '0;
        else        st_q     <= st_d;
    end

    assign head_o = st_q.ent[0];
    assign top_o  = st_q.ent[DEPTH-1];

    // R7
    top_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == ISS_NONE || (kind_i == ISS_WRITE && slot_i != IW'(DEPTH - 1))) |=> (top_o == '0));

endmodule

// File: rtl/ack_order_pipe.sv
module ack_order_pipe
    import ackp_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 4,
    localparam int EW   = TAG_W + 1,
    localparam int IW   = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_issue_i,
    input  logic             wr_issue_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             quiet_i,
    output logic             ack_o,
    output logic [TAG_W-1:0] tag_o
);

    typedef struct packed {
        logic             ack;
        logic [TAG_W-1:0] tag;
    } out_st_t;

    iss_kind_e     kind;
    logic [IW-1:0] slot;
    logic [EW-1:0] entry_in;
    logic [EW-1:0] head;
    logic [EW-1:0] top;
    out_st_t       out_d, out_q;

    assign kind     = iss_decode(rd_issue_i, wr_issue_i);
    assign entry_in = {tag_i, ~quiet_i};

    ackp_slot_ctrl #(.DEPTH(DEPTH)) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind_i (kind),
        .slot_o (slot)
    );

    ackp_shift_pipe #(.DEPTH(DEPTH), .EW(EW)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind_i  (kind),
        .slot_i  (slot),
        .entry_i (entry_in),
        .head_o  (head),
        .top_o   (top)
    );

    always_comb begin
        out_d.ack = head[0];
        out_d.tag = head[EW-1:1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ack_o = out_q.ack;
    assign tag_o = out_q.tag;

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_issue_i && wr_issue_i));

    // R2
    read_enters_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue_i |=> (top == {$past(tag_i), ~$past(quiet_i)}));

    // R6
    quiet_read_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue_i && quiet_i) |=> (top[0] == 1'b0));

endmodule

// File: tb/ack_order_pipe_tb.sv
`timescale 1ns/1ps
module ack_order_pipe_tb;

    localparam int DEPTH = 8;
    localparam int TAG_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_issue_i = 1'b0;
    logic             wr_issue_i = 1'b0;
    logic [TAG_W-1:0] tag_i = '0;
    logic             quiet_i = 1'b0;
    logic             ack_o;
    logic [TAG_W-1:0] tag_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_exp = -100;
    bit monitor_on = 1'b0;

    int               q_cyc[$];
    logic [TAG_W-1:0] q_tag[$];
    bit               q_ack[$];
    string            q_rq[$];

    always #10 clk = ~clk;

    ack_order_pipe #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_issue_i (rd_issue_i),
        .wr_issue_i (wr_issue_i),
        .tag_i      (tag_i),
        .quiet_i    (quiet_i),
        .ack_o      (ack_o),
        .tag_o      (tag_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic note_fail(string rq, string what, int act, int exp);
        fails++;
        $display("FAIL %s: %s actual=%0d expected=%0d (cycle %0d)", rq, what, act, exp, cyc);
    endtask

    // driver: issue one request at the current negedge, forecast its ack cycle
    task automatic issue(bit is_rd, logic [TAG_W-1:0] tg, bit quiet, string rq);
        int e;
        int ex;
        e = cyc + 1;
        if (is_rd) ex = e + DEPTH;
        else       ex = (e + 2 > last_exp + 1) ? e + 2 : last_exp + 1;
        last_exp = ex;
        q_cyc.push_back(ex);
        q_tag.push_back(tg);
        q_ack.push_back(!quiet);
        q_rq.push_back(rq);
        rd_issue_i = is_rd;
        wr_issue_i = !is_rd;
        tag_i      = tg;
        quiet_i    = quiet;
        @(negedge clk);
        rd_issue_i = 1'b0;
        wr_issue_i = 1'b0;
        quiet_i    = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: scoreboard compare each cycle
    always @(negedge clk) begin
        if (monitor_on) begin
            checks++;
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                if (ack_o !== q_ack[0])
                    note_fail(q_rq[0], "ack_o", int'(ack_o), int'(q_ack[0]));
                else if (q_ack[0] && tag_o !== q_tag[0])
                    note_fail(q_rq[0], "tag_o", int'(tag_o), int'(q_tag[0]));
                void'(q_cyc.pop_front());
                void'(q_tag.pop_front());
                void'(q_ack.pop_front());
                q_rq.delete(0);
            end else if (ack_o !== 1'b0) begin
                note_fail("R7", "unexpected ack_o", int'(ack_o), 0);
            end
        end
    end

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs idle right after reset
        checks++;
        if (ack_o !== 1'b0 || tag_o !== '0)
            note_fail("R1", "reset outputs", int'({ack_o, tag_o}), 0);
        monitor_on = 1'b1;
        // R1: first write after reset uses slot 1
        issue(1'b0, 4'h3, 1'b0, "R1");
        idle(4);
        // R2: single read
        issue(1'b1, 4'hA, 1'b0, "R2");
        idle(DEPTH + 2);
        // R3: write with no read in flight
        issue(1'b0, 4'h5, 1'b0, "R3");
        idle(3);
        // R4: write right after a read
        issue(1'b1, 4'h1, 1'b0, "R2");
        issue(1'b0, 4'h2, 1'b0, "R4");
        idle(DEPTH + 2);
        // R5: write three cycles after a read
        issue(1'b1, 4'h6, 1'b0, "R2");
        idle(2);
        issue(1'b0, 4'h7, 1'b0, "R5");
        idle(DEPTH + 2);
        // R5: write long after a read floors at slot 1
        issue(1'b1, 4'h8, 1'b0, "R2");
        idle(DEPTH + 3);
        issue(1'b0, 4'h9, 1'b0, "R5");
        idle(3);
        // R5: back-to-back writes behind a read
        issue(1'b1, 4'hB, 1'b0, "R2");
        issue(1'b0, 4'hC, 1'b0, "R5");
        issue(1'b0, 4'hD, 1'b0, "R5");
        issue(1'b0, 4'hE, 1'b0, "R5");
        idle(DEPTH + 2);
        // R6: suppressed requests hold their place
        issue(1'b1, 4'h4, 1'b1, "R6");
        issue(1'b0, 4'hF, 1'b0, "R6");
        issue(1'b0, 4'h0, 1'b1, "R6");
        issue(1'b0, 4'h2, 1'b0, "R6");
        idle(DEPTH + 2);
        // R7/R8: random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 3)      issue(1'b1, TAG_W'($urandom), ($urandom_range(0, 7) == 0), "R7");
            else if (r < 7) issue(1'b0, TAG_W'($urandom), ($urandom_range(0, 7) == 0), "R8");
            else            idle(1);
        end
        idle(DEPTH + 4);
        // R7: everything forecast has come out
        checks++;
        if (q_cyc.size() != 0)
            note_fail("R7", "acks left outstanding", q_cyc.size(), 0);
        monitor_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule